// File: doc/BRIEF.md
# Bus Cycle Tracker and Ready Generator

This block sits on the system side of a processor bus and follows the bus cycles that the processor starts. Each time the address strobe is sampled active, it captures the cycle's space (memory or I/O), its upper address bits and whether it is a data or control cycle. It sorts the cycle into a region: memory, programmed I/O, coprocessor, or unmapped I/O. While the cycle is current it raises that region's chip select. It counts out a per-region number of wait states and then returns a one-clock ready pulse. One bus state equals one clock.

The processor may pipeline its addresses, which means it can strobe the next cycle before the current one has been acknowledged. The tracker keeps one such early cycle in a pending slot. That cycle becomes current on the clock that follows the previous ready. No explicit idle signal exists on the bus, so idleness is inferred from the history of strobes and readys: the bus is busy while a current or pending cycle exists. A strobe that arrives while both slots are full is a protocol violation and sets a sticky error flag. The hold acknowledge input is reflected as a registered hold-state flag.

Top module: `busCycleTracker`

## Requirements
- R1: With a wait count of zero, ready is high in the bus state directly after the state in which the strobe was sampled. Ready is never high while the bus has been idle with no strobe in the previous state.
- R2: Each region has its own 4-bit wait input: memWait for memory, ioWait for programmed and unmapped I/O, cpWait for the coprocessor. A value of N delays ready by exactly N further bus states.
- R3: Region decode works on addr, which carries byte-address bits 23..3, with addr[20] being bit 23. memSpace=1 selects memory. memSpace=0 with addr equal to 0x10001F (byte addresses 0x8000F8..0x8000FF) selects the coprocessor. memSpace=0 with addr[20:13] all zero (byte addresses below 0x010000) selects programmed I/O. Every other I/O address is unmapped and gets no select. At most one select is high, and a select is high only while its cycle is current.
- R4: A strobe that arrives while a cycle is current and not in its ready state is held as pending. It becomes current on the clock after that ready, so its ready comes N+1 states after the previous ready. A strobe in the ready state itself also waits for that clock.
- R5: Every accepted strobe produces exactly one ready, and the readys come in strobe order. Each ready lasts one clock per cycle, so back-to-back zero-wait cycles give adjacent pulses.
- R6: busBusy goes high in the state after an accepted strobe to an idle bus. It falls in the state after the last outstanding ready.
- R7: holdState equals holdAck as sampled at the previous clock edge.
- R8: A strobe that arrives while a current cycle (not in its ready state) and a pending cycle both exist is dropped and produces no ready. It sets protoErr, which stays high until reset.
- R9: While rstN is low, ready, all selects, busBusy, holdState and protoErr are low.
- R10: A control cycle (dataCyc=0) receives ready after its region's wait count but asserts no chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus state clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrStrobe | input | 1 | New cycle address strobe, active high |
| addr | input | 21 | Byte-address bits 23..3 of the strobed cycle |
| memSpace | input | 1 | 1 = memory space, 0 = I/O space |
| dataCyc | input | 1 | 1 = data cycle, 0 = control cycle |
| holdAck | input | 1 | Processor hold acknowledge |
| memWait | input | 4 | Wait states for memory cycles |
| ioWait | input | 4 | Wait states for I/O and unmapped I/O cycles |
| cpWait | input | 4 | Wait states for coprocessor cycles |
| ready | output | 1 | One-clock cycle acknowledge |
| memSel | output | 1 | Memory chip select |
| ioSel | output | 1 | Programmed I/O chip select |
| cpSel | output | 1 | Coprocessor select |
| busBusy | output | 1 | A cycle is current or pending |
| holdState | output | 1 | Bus is in hold acknowledge |
| protoErr | output | 1 | Sticky strobe-overflow flag |

## Verification
Isolated cycles separated by idle states check the decode and the wait count of each region, including an I/O address with bit 23 high that lies just outside the coprocessor window. Two pipelined bursts are then run. In the first, with memory waits, the second strobe lands in the pending slot and the third lands just after a promotion, which shows whether the pending cycle's count starts at the right clock. In the second, zero-wait strobes come on every state, which shows whether back-to-back readys stay in order and are never merged. A third strobe that arrives while both slots are full tells a correct drop, with no extra ready, apart from a silently accepted cycle, and a reset then clears the error flag.

// File: rtl/busTrkPkg.sv
package busTrkPkg;
  localparam int BYTE_ADDR_W = 24;
  localparam int ADDR_LSB    = 3;
  localparam int ADDR_W      = BYTE_ADDR_W - ADDR_LSB;
  localparam int IO_SPAN_W   = 16;
  localparam int IO_TOP_W    = BYTE_ADDR_W - IO_SPAN_W;
  localparam logic [BYTE_ADDR_W-1:0] CP_BASE = 24'h8000F8;
  localparam logic [ADDR_W-1:0] CP_KEY = CP_BASE[BYTE_ADDR_W-1:ADDR_LSB];

  typedef enum logic [1:0] {
    RGN_MEM  = 2'd0,
    RGN_IO   = 2'd1,
    RGN_CP   = 2'd2,
    RGN_OPEN = 2'd3
  } region_e;

  typedef struct packed {
    logic    isData;
    region_e region;
  } cycInfo_t;

  typedef struct packed {
    logic loadCur;
    logic loadPend;
    logic promote;
  } ctlStrobe_t;
endpackage

// File: rtl/busTrkDatapath.sv
module busTrkDatapath
  import busTrkPkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                ctl,
  input  logic                      curValid,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      memSpace,
  input  logic                      dataCyc,
  input  logic [WAIT_W-1:0]         memWait,
  input  logic [WAIT_W-1:0]         ioWait,
  input  logic [WAIT_W-1:0]         cpWait,
  output logic [WAIT_W-1:0]         busWait,
  output logic [WAIT_W-1:0]         pendWait,
  output logic                      memSel,
  output logic                      ioSel,
  output logic                      cpSel
);

  cycInfo_t busInfo;
  cycInfo_t curInfo;
  cycInfo_t pendInfo;
  logic     ioTopClear;
  logic     cpHit;

  // Region decode of the cycle now on the bus
  always_comb begin
    ioTopClear     = (addr[ADDR_W-1 -: IO_TOP_W] == '0);
    cpHit          = (addr == CP_KEY);
    busInfo.isData = dataCyc;
    if (memSpace)        busInfo.region = RGN_MEM;
    else if (cpHit)      busInfo.region = RGN_CP;
    else if (ioTopClear) busInfo.region = RGN_IO;
    else                 busInfo.region = RGN_OPEN;
  end

  function automatic logic [WAIT_W-1:0] waitOf(input region_e rgn,
                                               input logic [WAIT_W-1:0] wm,
                                               input logic [WAIT_W-1:0] wi,
                                               input logic [WAIT_W-1:0] wc);
    case (rgn)
      RGN_MEM: waitOf = wm;
      RGN_CP:  waitOf = wc;
      default: waitOf = wi;
    endcase
  endfunction

  assign busWait  = waitOf(busInfo.region,  memWait, ioWait, cpWait);
  assign pendWait = waitOf(pendInfo.region, memWait, ioWait, cpWait);

  // Current and pending cycle slots
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curInfo  <= '0;
      pendInfo <= '0;
    end else begin
      if (ctl.loadCur)      curInfo <= busInfo;
      else if (ctl.promote) curInfo <= pendInfo;
      if (ctl.loadPend)     pendInfo <= busInfo;
    end
  end

  logic selGate;
  assign selGate = curValid && curInfo.isData;
  assign memSel  = selGate && (curInfo.region == RGN_MEM);
  assign ioSel   = selGate && (curInfo.region == RGN_IO);
  assign cpSel   = selGate && (curInfo.region == RGN_CP);

endmodule

// File: rtl/busTrkControl.sv
module busTrkControl
  import busTrkPkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStrobe,
  input  logic              holdAck,
  input  logic [WAIT_W-1:0] busWait,
  input  logic [WAIT_W-1:0] pendWait,
  output ctlStrobe_t        ctl,
  output logic              curValid,
  output logic              pendValid,
  output logic              ready,
  output logic              holdState,
  output logic              protoErr
);

  logic [WAIT_W-1:0] waitCnt;
  logic              readyNow;
  logic              overflow;

  assign readyNow = curValid && (waitCnt == '0);
  assign ready    = readyNow;
  assign overflow = addrStrobe && curValid && pendValid && !readyNow;

  always_comb begin
    ctl = '0;
    if (readyNow) begin
      if (pendValid) begin
        ctl.promote  = 1'b1;
        ctl.loadPend = addrStrobe;
      end else begin
        ctl.loadCur  = addrStrobe;
      end
    end else if (curValid) begin
      ctl.loadPend = addrStrobe && !pendValid;
    end else begin
      ctl.loadCur = addrStrobe;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curValid  <= 1'b0;
      pendValid <= 1'b0;
      waitCnt   <= '0;
      holdState <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      curValid  <= ctl.loadCur || ctl.promote || (curValid && !readyNow);
      pendValid <= ctl.loadPend || (pendValid && !ctl.promote);
      if (ctl.loadCur)                   waitCnt <= busWait;
      else if (ctl.promote)              waitCnt <= pendWait;
      else if (curValid && !readyNow)    waitCnt <= waitCnt - 1'b1;
      holdState <= holdAck;
      protoErr  <= protoErr || overflow;
    end
  end

endmodule

// File: rtl/busCycleTracker.sv
module busCycleTracker
  import busTrkPkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStrobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              memSpace,
  input  logic              dataCyc,
  input  logic              holdAck,
  input  logic [WAIT_W-1:0] memWait,
  input  logic [WAIT_W-1:0] ioWait,
  input  logic [WAIT_W-1:0] cpWait,
  output logic              ready,
  output logic              memSel,
  output logic              ioSel,
  output logic              cpSel,
  output logic              busBusy,
  output logic              holdState,
  output logic              protoErr
);

  ctlStrobe_t        ctl;
  logic              curValid;
  logic              pendValid;
  logic [WAIT_W-1:0] busWait;
  logic [WAIT_W-1:0] pendWait;

  busTrkControl #(.WAIT_W(WAIT_W)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .addrStrobe(addrStrobe),
    .holdAck   (holdAck),
    .busWait   (busWait),
    .pendWait  (pendWait),
    .ctl       (ctl),
    .curValid  (curValid),
    .pendValid (pendValid),
    .ready     (ready),
    .holdState (holdState),
    .protoErr  (protoErr)
  );

  busTrkDatapath #(.WAIT_W(WAIT_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .curValid(curValid),
    .addr    (addr),
    .memSpace(memSpace),
    .dataCyc (dataCyc),
    .memWait (memWait),
    .ioWait  (ioWait),
    .cpWait  (cpWait),
    .busWait (busWait),
    .pendWait(pendWait),
    .memSel  (memSel),
    .ioSel   (ioSel),
    .cpSel   (cpSel)
  );

  assign busBusy = curValid || pendValid;

endmodule

// File: rtl/busTrkChecker.sv
module busTrkChecker (
  input logic clk,
  input logic rstN,
  input logic addrStrobe,
  input logic ready,
  input logic memSel,
  input logic ioSel,
  input logic cpSel,
  input logic busBusy,
  input logic protoErr
);

  assert_ready_owned_R5: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> busBusy);

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memSel, ioSel, cpSel}));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  assert_wake_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && !busBusy) |=> busBusy);

  assert_idle_after_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busBusy) |-> $past(ready));

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busBusy && !addrStrobe) |=> !ready);

endmodule

bind busCycleTracker busTrkChecker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .addrStrobe(addrStrobe),
  .ready     (ready),
  .memSel    (memSel),
  .ioSel     (ioSel),
  .cpSel     (cpSel),
  .busBusy   (busBusy),
  .protoErr  (protoErr)
);

// File: tb/sim_busCycleTracker.sv
module sim_busCycleTracker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        addrStrobe;
  logic [20:0] addr;
  logic        memSpace;
  logic        dataCyc;
  logic        holdAck;
  logic [3:0]  memWait;
  logic [3:0]  ioWait;
  logic [3:0]  cpWait;
  logic        ready;
  logic        memSel;
  logic        ioSel;
  logic        cpSel;
  logic        busBusy;
  logic        holdState;
  logic        protoErr;

  busCycleTracker u0 (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .addr(addr),
    .memSpace(memSpace), .dataCyc(dataCyc), .holdAck(holdAck),
    .memWait(memWait), .ioWait(ioWait), .cpWait(cpWait),
    .ready(ready), .memSel(memSel), .ioSel(ioSel), .cpSel(cpSel),
    .busBusy(busBusy), .holdState(holdState), .protoErr(protoErr)
  );

  always #2.5ns clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         edgeNo;
    logic [2:0] sel;
    string      req;
  } exp_t;

  exp_t expQ[$];
  int   nChk = 0;
  int   nFail = 0;
  int   lastR = -10;
  int   prevR = -10;
  logic wantRdy;
  bit   done = 0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  endtask

  // Region model taken from R2/R3/R10
  function automatic logic [2:0] selFor(input logic m, input logic [20:0] a, input logic dc);
    logic [2:0] s;
    if (m)                    s = 3'b100;
    else if (a == 21'h10001F) s = 3'b001;
    else if (a[20:13] == 8'd0) s = 3'b010;
    else                      s = 3'b000;
    return dc ? s : 3'b000;
  endfunction

  function automatic int waitFor(input logic m, input logic [20:0] a);
    if (m) return int'(memWait);
    if (a == 21'h10001F) return int'(cpWait);
    return int'(ioWait);
  endfunction

  // Driver: gap = idle states before this strobe
  task automatic issue(input int gap, input logic m, input logic [20:0] a,
                       input logic dc, input string req);
    int e;
    int loadAt;
    exp_t it;
    if (gap > 0) begin
      addrStrobe = 1'b0;
      repeat (gap) @(negedge clk);
    end
    addrStrobe = 1'b1;
    addr       = a;
    memSpace   = m;
    dataCyc    = dc;
    e = cyc + 1;
    if (prevR >= e) begin
      // both slots full: dropped (R8)
    end else begin
      loadAt    = (e > lastR + 1) ? e : lastR + 1;
      it.edgeNo = loadAt + waitFor(m, a);
      it.sel    = selFor(m, a, dc);
      it.req    = req;
      expQ.push_back(it);
      prevR = lastR;
      lastR = it.edgeNo;
    end
    @(negedge clk);
  endtask

  task automatic drain();
    addrStrobe = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares every ready against the scoreboard
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      wantRdy = (expQ.size() > 0) && (expQ[0].edgeNo == cyc);
      if (wantRdy) begin
        exp_t it;
        it = expQ.pop_front();
        check({it.req, " R5 ready"}, {7'd0, ready}, 8'd1);
        check({it.req, " select"}, {5'd0, memSel, ioSel, cpSel}, {5'd0, it.sel});
      end else if (ready) begin
        check("R5 unexpected ready", {7'd0, ready}, 8'd0);
      end
    end
  end

  initial begin
    #(5ns * 100000);
    nChk++;
    nFail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    finishRun();
  end

  initial begin
    rstN = 1'b0; addrStrobe = 1'b0; addr = '0; memSpace = 1'b0; dataCyc = 1'b0;
    holdAck = 1'b0; memWait = 4'd0; ioWait = 4'd2; cpWait = 4'd1;
    repeat (3) @(negedge clk);
    check("R9 ready", {7'd0, ready}, 8'd0);
    check("R9 selects", {5'd0, memSel, ioSel, cpSel}, 8'd0);
    check("R9 busy", {7'd0, busBusy}, 8'd0);
    check("R9 hold", {7'd0, holdState}, 8'd0);
    check("R9 err", {7'd0, protoErr}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);

    // isolated cycles per region
    issue(1, 1'b1, 21'h0ABCD, 1'b1, "R1 zero-wait mem");
    check("R6 busy after strobe", {7'd0, busBusy}, 8'd1);
    drain();
    check("R6 idle after ready", {7'd0, busBusy}, 8'd0);
    issue(2, 1'b0, 21'h00007F, 1'b1, "R2 io wait 2");
    drain();
    issue(2, 1'b0, 21'h10001F, 1'b1, "R3 coprocessor");
    drain();
    issue(2, 1'b0, 21'h10001E, 1'b1, "R3 unmapped A23 io");
    drain();
    issue(2, 1'b0, 21'h002000, 1'b1, "R3 unmapped high io");
    drain();
    issue(2, 1'b1, 21'h00007F, 1'b0, "R10 control cycle");
    drain();

    // pipelined with waits
    memWait = 4'd3;
    issue(1, 1'b1, 21'h000100, 1'b1, "R4 first");
    issue(0, 1'b0, 21'h00007F, 1'b1, "R4 pending");
    issue(2, 1'b1, 21'h000200, 1'b1, "R4 after promote");
    drain();
    check("R8 no error yet", {7'd0, protoErr}, 8'd0);

    // zero-wait burst, strobe every state
    memWait = 4'd0;
    issue(1, 1'b1, 21'h000300, 1'b1, "R5 burst a");
    issue(0, 1'b0, 21'h10001F, 1'b1, "R5 burst b");
    issue(0, 1'b1, 21'h000301, 1'b1, "R5 burst c");
    issue(0, 1'b1, 21'h000302, 1'b1, "R5 burst d");
    drain();
    check("R6 idle after burst", {7'd0, busBusy}, 8'd0);

    // hold acknowledge
    holdAck = 1'b1;
    @(negedge clk);
    check("R7 hold set", {7'd0, holdState}, 8'd1);
    holdAck = 1'b0;
    @(negedge clk);
    check("R7 hold clear", {7'd0, holdState}, 8'd0);

    // overflow
    memWait = 4'd3;
    issue(1, 1'b1, 21'h000400, 1'b1, "R8 cur");
    issue(0, 1'b1, 21'h000401, 1'b1, "R8 pend");
    issue(0, 1'b1, 21'h000402, 1'b1, "R8 dropped");
    check("R8 error set", {7'd0, protoErr}, 8'd1);
    drain();
    check("R8 error sticky", {7'd0, protoErr}, 8'd1);
    rstN = 1'b0;
    @(negedge clk);
    check("R8 error cleared by reset", {7'd0, protoErr}, 8'd0);
    lastR = -10;
    prevR = -10;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 nothing left", expQ.size() == 0 ? 8'd1 : 8'd0, 8'd1);
    finishRun();
  end

endmodule